// File: doc/BRIEF.md
# SPMI Command Mailbox

A set of memory-mapped software channels through which a processor issues single register reads and writes toward a power-management bus master. Each channel holds a write-data register, a command register, a read-data register, a valid-clear register and a status register. Software loads the write data, then writes a command word, which launches the transaction. It then polls the status register, whose channel state code tells it when the transfer is finished.

On the far side, a shared valid/ready request port carries the command word and the write data to a bus-master stub. Once a request is offered, the command and the write data hold steady until `req_ready` is seen high, so the stub may apply back-pressure for as many cycles as it needs. Reads come back on a response strobe with no ready signal, because the issuing channel is always waiting when a response arrives.

A completed read parks in a waiting state with its data until software acknowledges it. A write goes back to idle as soon as the stub accepts it. Channels share the port under a fixed priority, and only one transaction is in flight at a time.

Top module: `spmi_mbox`

## Requirements
- R1: After reset, every channel's status, write-data and read-data registers read zero, and `req_valid` is low.
- R2: The status register (channel offset 0x28) holds the state code in bits [3:1] and a sticky error flag in bit 0. The other bits read zero. Code 0 is idle, 1 is request pending, 2 is awaiting response, and 6 is waiting for valid-clear.
- R3: A command write (offset 0x00) in idle moves the channel to code 1. The channel then offers the command word unchanged on `req_cmd`, and the word reads back at offset 0x00. While `req_ready` is low, `req_valid`, `req_cmd` and `req_wdata` hold steady.
- R4: The command word has these fields: bits [31:30] hold the command type, bit 29 is 1 for a write, bits [27:24] hold the slave id, bits [17:16] hold the length minus one, and bits [15:0] hold the register address. A write command returns the channel to code 0 on the cycle after its handshake and never enters code 6.
- R5: A read command (bit 29 = 0) moves the channel to code 2 after its handshake. It moves to code 6, with the data captured, on the cycle after `rsp_valid` is sampled.
- R6: Data bytes sit least significant first. Bytes above the length field are zero, both in `req_wdata` and in the captured read data (offset 0x14).
- R7: Writing a word with bit 0 set to valid-clear (offset 0x24) in code 6 returns the channel to code 0. Such a write in any other state leaves the state unchanged, and a valid-clear write with bit 0 clear does nothing.
- R8: A command write outside idle is ignored: the stored command and the state stay as they were, no request is issued, and status bit 0 is set. A valid-clear write with bit 0 set clears that bit.
- R9: A write-data write (offset 0x04) outside idle leaves the stored write data unchanged.
- R10: Channel n sits at byte address 0x40*n. Addresses past the last channel read zero. Pending channels are served lowest index first, one transaction at a time, and each response returns to the channel that issued the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address: channel index in bits above 5, offset in bits [5:0] |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational readback of the register at `bus_addr` |
| req_valid | output | 1 | Request offered to the bus master |
| req_ready | input | 1 | Bus master accepts the request |
| req_cmd | output | 32 | Command word of the offered request |
| req_wdata | output | 32 | Length-masked write data of the offered request |
| rsp_valid | input | 1 | Read response strobe |
| rsp_rdata | input | 32 | Read response data |

## Verification
Code 1 is visible on the first negative edge after the command write. With `req_ready` high, a write is back to code 0, and a read is in code 2, two clock edges after the command edge. With a stub latency of L cycles, a read reaches code 6 L edges after that. The bench samples status at exactly these negative edges, not by open-ended polling, except in the long-latency priority scenario, which polls with a cycle limit. Under back-pressure, the request fields are compared on several successive cycles before `req_ready` is raised, and idle is expected one edge after the raise.

// File: rtl/spmi_mbox_pkg.sv
package spmi_mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_VCLR = 3'd6
  } mbox_state_e;

  localparam logic [OFS_W-1:0] OFS_CMD   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_WDATA = 6'h04;
  localparam logic [OFS_W-1:0] OFS_RDATA = 6'h14;
  localparam logic [OFS_W-1:0] OFS_VCLR  = 6'h24;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h28;

  localparam int unsigned CMD_WR_BIT  = 29;
  localparam int unsigned CMD_LEN_LSB = 16;

  // keep bytes 0..len, zero the rest
  function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] d,
                                                   input logic [1:0] len);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W/8; b++)
      if (b <= int'(len)) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/spmi_mbox_chan.sv
module spmi_mbox_chan
  import spmi_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_wdata,
  input  logic              wr_vclr,
  input  logic [WORD_W-1:0] wr_val,
  input  logic              grant,
  input  logic              rsp_hit,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              req,
  output logic [2:0]        state_o,
  output logic              err_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] wd_o,
  output logic [WORD_W-1:0] rd_o
);
  mbox_state_e       state;
  logic              err_q;
  logic [WORD_W-1:0] cmd_q, wd_q, rd_q;
  logic              clr_req;

  assign clr_req = wr_vclr && wr_val[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err_q <= 1'b0;
      cmd_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (wr_cmd) begin
          cmd_q <= wr_val;
          state <= ST_REQ;
        end
        ST_REQ:  if (grant) state <= cmd_q[CMD_WR_BIT] ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (rsp_hit) begin
          rd_q  <= keep_bytes(rsp_data, cmd_q[CMD_LEN_LSB +: 2]);
          state <= ST_VCLR;
        end
        ST_VCLR: if (clr_req) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (wr_wdata && state == ST_IDLE) wd_q <= wr_val;
      if (clr_req) err_q <= 1'b0;
      else if (wr_cmd && state != ST_IDLE) err_q <= 1'b1;
    end
  end

  assign req     = (state == ST_REQ);
  assign state_o = state;
  assign err_o   = err_q;
  assign cmd_o   = cmd_q;
  assign wd_o    = wd_q;
  assign rd_o    = rd_q;
endmodule

// File: rtl/spmi_mbox_arb.sv
module spmi_mbox_arb #(
  parameter int unsigned NUM_CHAN = 3,
  localparam int unsigned IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CHAN-1:0] req,
  input  logic                write_sel,
  input  logic                req_ready,
  input  logic                rsp_valid,
  output logic [IDX_W-1:0]    sel_o,
  output logic                issue_o,
  output logic [NUM_CHAN-1:0] grant,
  output logic [NUM_CHAN-1:0] rsp_hit
);
  typedef enum logic [1:0] {A_FREE, A_ISSUE, A_RESP} arb_phase_e;
  arb_phase_e       phase;
  logic [IDX_W-1:0] sel_q, pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_CHAN-1; i >= 0; i--)
      if (req[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= A_FREE;
      sel_q <= '0;
    end else begin
      case (phase)
        A_FREE:  if (|req) begin
          sel_q <= pick;
          phase <= A_ISSUE;
        end
        A_ISSUE: if (req_ready) phase <= write_sel ? A_FREE : A_RESP;
        A_RESP:  if (rsp_valid) phase <= A_FREE;
        default: phase <= A_FREE;
      endcase
    end
  end

  assign issue_o = (phase == A_ISSUE);
  assign sel_o   = sel_q;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_route
    assign grant[g]   = issue_o && req_ready && (sel_q == IDX_W'(g));
    assign rsp_hit[g] = (phase == A_RESP) && rsp_valid && (sel_q == IDX_W'(g));
  end
endmodule

// File: rtl/spmi_mbox.sv
module spmi_mbox
  import spmi_mbox_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 3,
  localparam int unsigned IDX_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [WORD_W-1:0] req_cmd,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata
);
  logic [IDX_W-1:0]            bus_idx;
  logic [OFS_W-1:0]            bus_ofs;
  logic [NUM_CHAN-1:0]         ch_req, ch_grant, ch_rsp, ch_err;
  logic [NUM_CHAN-1:0][2:0]    chan_st;
  logic [WORD_W-1:0]           cmd_a [NUM_CHAN];
  logic [WORD_W-1:0]           wd_a  [NUM_CHAN];
  logic [WORD_W-1:0]           rd_a  [NUM_CHAN];
  logic [IDX_W-1:0]            sel;
  logic [WORD_W-1:0]           sel_cmd, sel_wd;

  assign bus_idx = bus_addr[ADDR_W-1:OFS_W];
  assign bus_ofs = bus_addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    logic hit;
    assign hit = bus_wr_en && (bus_idx == IDX_W'(g));
    spmi_mbox_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (hit && bus_ofs == OFS_CMD),
      .wr_wdata (hit && bus_ofs == OFS_WDATA),
      .wr_vclr  (hit && bus_ofs == OFS_VCLR),
      .wr_val   (bus_wdata),
      .grant    (ch_grant[g]),
      .rsp_hit  (ch_rsp[g]),
      .rsp_data (rsp_rdata),
      .req      (ch_req[g]),
      .state_o  (chan_st[g]),
      .err_o    (ch_err[g]),
      .cmd_o    (cmd_a[g]),
      .wd_o     (wd_a[g]),
      .rd_o     (rd_a[g])
    );
  end

  spmi_mbox_arb #(.NUM_CHAN(NUM_CHAN)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (ch_req),
    .write_sel (sel_cmd[CMD_WR_BIT]),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .sel_o     (sel),
    .issue_o   (req_valid),
    .grant     (ch_grant),
    .rsp_hit   (ch_rsp)
  );

  always_comb begin
    sel_cmd = '0;
    sel_wd  = '0;
    for (int i = 0; i < NUM_CHAN; i++)
      if (sel == IDX_W'(i)) begin
        sel_cmd = cmd_a[i];
        sel_wd  = wd_a[i];
      end
  end

  assign req_cmd   = sel_cmd;
  assign req_wdata = keep_bytes(sel_wd, sel_cmd[CMD_LEN_LSB +: 2]);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CHAN; i++)
      if (bus_idx == IDX_W'(i)) begin
        case (bus_ofs)
          OFS_CMD:   bus_rdata = cmd_a[i];
          OFS_WDATA: bus_rdata = wd_a[i];
          OFS_RDATA: bus_rdata = rd_a[i];
          OFS_STAT:  bus_rdata = {28'd0, chan_st[i], ch_err[i]};
          default:   bus_rdata = '0;
        endcase
      end
  end
endmodule

// File: rtl/spmi_mbox_chk.sv
module spmi_mbox_chk #(
  parameter int unsigned NUM_CHAN = 3,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr_en,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [31:0]              bus_wdata,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [31:0]              req_cmd,
  input logic [31:0]              req_wdata,
  input logic                     rsp_valid,
  input logic [NUM_CHAN-1:0][2:0] chan_st
);
  logic [5:0]          sh;
  logic [NUM_CHAN-1:0] waiting;

  assign sh = ({4'd0, req_cmd[17:16]} + 6'd1) << 3;

  always_comb
    for (int i = 0; i < NUM_CHAN; i++) waiting[i] = (chan_st[i] == 3'd2);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_cmd) && $stable(req_wdata));

  // R6
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_wdata >> sh) == 32'd0));

  // R10
  one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(waiting) <= 1);

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_ch
    logic clr;
    assign clr = bus_wr_en && bus_wdata[0] && (bus_addr == ADDR_W'(g*64 + 36));

    // R2
    st_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_st[g] == 3'd0 || chan_st[g] == 3'd1 || chan_st[g] == 3'd2 || chan_st[g] == 3'd6);

    // R7
    vclr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_st[g] == 3'd6 && !clr |=> chan_st[g] == 3'd6);

    // R5
    rsp_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_st[g] == 3'd2 && rsp_valid |=> chan_st[g] == 3'd6);
  end
endmodule

bind spmi_mbox spmi_mbox_chk #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .chan_st   (chan_st)
);

// File: tb/spmi_mbox_bench.sv
`timescale 1ns/1ps
module spmi_mbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_cmd, req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spmi_mbox u_spmi_mbox (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // bus-master stub
  int          rsp_lat = 3;
  logic [31:0] rsp_next = '0;
  logic [31:0] hs_log [32];
  logic [31:0] last_wd = '0;
  int          hs_cnt = 0;
  initial begin
    int cnt;
    logic [31:0] pend;
    cnt = 0; pend = '0;
    forever begin
      @(negedge clk); #2;
      rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin rsp_valid = 1'b1; rsp_rdata = pend; end
      end
      if (req_valid && req_ready) begin
        hs_log[hs_cnt % 32] = req_cmd;
        last_wd = req_wdata;
        hs_cnt++;
        if (!req_cmd[29]) begin cnt = rsp_lat; pend = rsp_next; end
      end
    end
  end

  function automatic logic [31:0] trim(input logic [31:0] d, input logic [1:0] n);
    case (n)
      2'd0: return d & 32'h0000_00FF;
      2'd1: return d & 32'h0000_FFFF;
      2'd2: return d & 32'h00FF_FFFF;
      default: return d;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] adr(input int ch, input logic [5:0] ofs);
    return 8'(ch * 64) + {2'b00, ofs};
  endfunction

  function automatic logic [31:0] mk_cmd(input logic wr, input logic [3:0] sid,
                                         input logic [1:0] len, input logic [15:0] a);
    return {(wr ? 2'd1 : 2'd3), wr, 1'b0, sid, 6'd0, len, a};
  endfunction

  typedef struct packed {
    logic        wr;
    logic [1:0]  ch;
    logic [1:0]  len;
    logic [15:0] addr;
    logic [3:0]  sid;
    logic [31:0] wd;
    logic [31:0] rsp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 2'd0, 2'd0, 16'h0012, 4'd3,  32'hDEADBEEF, 32'h0},
    '{1'b0, 2'd0, 2'd3, 16'h1234, 4'd5,  32'h0,        32'hCAFEF00D},
    '{1'b0, 2'd1, 2'd0, 16'h00FF, 4'd15, 32'h0,        32'h89ABCDEF},
    '{1'b1, 2'd2, 2'd2, 16'hFFFF, 4'd0,  32'h11223344, 32'h0},
    '{1'b0, 2'd2, 2'd1, 16'h0400, 4'd9,  32'h0,        32'h55AA66BB},
    '{1'b1, 2'd1, 2'd3, 16'h8001, 4'd7,  32'hA5A5C3C3, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, c1, c2;
    int base, guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 out-of-range channel
    for (int ch = 0; ch < 3; ch++) begin
      bus_rd(adr(ch, 6'h28), d); chk("R1 status", d, 32'h0);
      bus_rd(adr(ch, 6'h04), d); chk("R1 wdata", d, 32'h0);
      bus_rd(adr(ch, 6'h14), d); chk("R1 rdata", d, 32'h0);
    end
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    bus_rd(adr(3, 6'h28), d); chk("R10 unmapped channel", d, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      c = mk_cmd(VEC[v].wr, VEC[v].sid, VEC[v].len, VEC[v].addr);
      rsp_next = VEC[v].rsp;
      base = hs_cnt;
      bus_wr(adr(VEC[v].ch, 6'h04), VEC[v].wd);
      bus_wr(adr(VEC[v].ch, 6'h00), c);
      bus_rd(adr(VEC[v].ch, 6'h28), d); chk("R2 R3 pending code", d, 32'h2);
      bus_rd(adr(VEC[v].ch, 6'h00), d); chk("R3 command readback", d, c);
      @(negedge clk);
      chk("R3 req_valid", {31'd0, req_valid}, 32'd1);
      chk("R3 req_cmd", req_cmd, c);
      chk("R6 req_wdata", req_wdata, trim(VEC[v].wd, VEC[v].len));
      @(negedge clk);
      bus_rd(adr(VEC[v].ch, 6'h28), d);
      if (VEC[v].wr) begin
        chk("R4 write back to idle", d, 32'h0);
        chk("R4 one handshake", 32'(hs_cnt - base), 32'd1);
        chk("R4 stub saw write data", last_wd, trim(VEC[v].wd, VEC[v].len));
      end else begin
        chk("R5 awaiting response", d, 32'h4);
        repeat (rsp_lat) @(negedge clk);
        bus_rd(adr(VEC[v].ch, 6'h28), d); chk("R5 wait valid-clear", d, 32'hC);
        bus_rd(adr(VEC[v].ch, 6'h14), d); chk("R6 read data masked", d, trim(VEC[v].rsp, VEC[v].len));
        bus_wr(adr(VEC[v].ch, 6'h24), 32'h0);
        bus_rd(adr(VEC[v].ch, 6'h28), d); chk("R7 clear with bit0 low ignored", d, 32'hC);
        bus_wr(adr(VEC[v].ch, 6'h24), 32'h1);
        bus_rd(adr(VEC[v].ch, 6'h28), d); chk("R7 clear to idle", d, 32'h0);
      end
    end

    // R3 back-pressure
    req_ready = 1'b0;
    c = mk_cmd(1'b1, 4'd2, 2'd1, 16'h0777);
    bus_wr(adr(1, 6'h04), 32'h0000BEEF);
    bus_wr(adr(1, 6'h00), c);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R3 held valid", {31'd0, req_valid}, 32'd1);
      chk("R3 held cmd", req_cmd, c);
      chk("R3 held wdata", req_wdata, 32'h0000BEEF);
      bus_rd(adr(1, 6'h28), d); chk("R2 code 1 under stall", d, 32'h2);
      @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    bus_rd(adr(1, 6'h28), d); chk("R4 idle after late ready", d, 32'h0);

    // long read on channel 0 with busy-state corner cases, then priority
    rsp_lat = 40;
    rsp_next = 32'h7E57_0001;
    bus_wr(adr(0, 6'h04), 32'h0000_1111);
    c = mk_cmd(1'b0, 4'd1, 2'd3, 16'h0042);
    bus_wr(adr(0, 6'h00), c);
    repeat (2) @(negedge clk);
    bus_rd(adr(0, 6'h28), d); chk("R5 code 2", d, 32'h4);
    bus_wr(adr(0, 6'h24), 32'h1);
    bus_rd(adr(0, 6'h28), d); chk("R7 clear ignored in code 2", d, 32'h4);
    bus_wr(adr(0, 6'h00), mk_cmd(1'b1, 4'd4, 2'd0, 16'h0001));
    bus_rd(adr(0, 6'h28), d); chk("R8 error bit set, state kept", d, 32'h5);
    bus_rd(adr(0, 6'h00), d); chk("R8 command unchanged", d, c);
    bus_wr(adr(0, 6'h04), 32'h2222_2222);
    bus_rd(adr(0, 6'h04), d); chk("R9 wdata unchanged", d, 32'h0000_1111);
    base = hs_cnt;
    c2 = mk_cmd(1'b1, 4'd12, 2'd0, 16'h0202);
    c1 = mk_cmd(1'b1, 4'd11, 2'd0, 16'h0101);
    bus_wr(adr(2, 6'h00), c2);
    bus_wr(adr(1, 6'h00), c1);
    chk("R8 no extra request", 32'(hs_cnt - base), 32'd0);
    guard = 0;
    do begin
      @(negedge clk);
      bus_rd(adr(0, 6'h28), d);
      guard++;
    end while (d[3:1] != 3'd6 && guard < 200);
    chk("R10 response to issuer", d, 32'hD);
    bus_rd(adr(0, 6'h14), d); chk("R10 issuer data", d, 32'h7E57_0001);
    guard = 0;
    while (hs_cnt - base < 2 && guard < 50) begin @(negedge clk); guard++; end
    chk("R10 lower index first", hs_log[base % 32], c1);
    chk("R10 then next", hs_log[(base + 1) % 32], c2);
    bus_wr(adr(0, 6'h24), 32'h1);
    bus_rd(adr(0, 6'h28), d); chk("R8 error cleared with valid-clear", d, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule